// File: doc/BRIEF.md
# Branch and Skip PC Controller

This block works out where program flow goes next for the control-transfer instructions of a small 8-bit processor. Each clock it takes the current program counter together with a decoded operation code, a signed displacement, a status-flag selector, the status byte, the outcome of a register or I/O bit test, a register-equality result, the 16-bit indirect pointer and a flag saying whether the instruction after this one spans two words. From these it produces the next program counter, a flag that says whether the flow left the plain sequential path, and the number of cycles the instruction occupies.

It handles conditional branches on any single status flag (set or clear), signed greater-or-equal and less-than branches, relative jumps, indirect jumps and the three kinds of skip. A skip that fires jumps over the following instruction, so its advance and its cycle count depend on that instruction's length. The result is registered: outputs show the answer for the inputs sampled at the previous rising clock edge. Stack handling and instruction fetch belong to neighbouring blocks.

Top module: `brskip_pc`

## Requirements
- R1: While `rst_n` is low, and until the first rising edge after it rises, `next_pc_o`, `taken_o` and `cycles_o` are all zero.
- R2: Outputs reflect the inputs sampled at the previous rising edge. Operation code 0 (sequential) and the unused codes 10 to 15 give `next_pc_o` = PC + 1, `taken_o` = 0, `cycles_o` = 1.
- R3: Code 1 branches when status bit `sel_in` is 1 and code 2 branches when it is 0. Status bit positions: 0 carry, 1 zero, 2 negative, 3 overflow, 4 sign, 5 half carry, 6 transfer bit, 7 interrupt enable.
- R4: A taken branch (codes 1 to 4) gives PC + sext(offset_in[6:0]) + 1 and 2 cycles; a branch not taken gives PC + 1 and 1 cycle. offset_in[11:7] has no effect on branches.
- R5: Code 3 (signed greater-or-equal) is taken when status bit 2 XOR status bit 3 is 0; code 4 (signed less-than) when it is 1. Neither uses `sel_in` or status bit 4.
- R6: Code 5 (relative jump) always gives PC + sext(offset_in[11:0]) + 1, `taken_o` = 1 and 2 cycles.
- R7: Code 6 (indirect jump) gives `next_pc_o` with bits 15..0 equal to `zptr_in` and all higher bits zero, `taken_o` = 1, 2 cycles.
- R8: Code 7 skips when `regs_eq_in` is 1, code 8 when `bit_val_in` is 0, code 9 when `bit_val_in` is 1. A skip whose condition fails gives PC + 1, `taken_o` = 0, 1 cycle.
- R9: A skip whose condition holds gives `taken_o` = 1 and PC + 2 with 2 cycles when `next_two_word_in` is 0, or PC + 3 with 3 cycles when it is 1.
- R10: All program counter arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_in | input | PC_W (22) | Program counter of the current instruction |
| op_in | input | 4 | Decoded operation code |
| offset_in | input | 12 | Signed displacement (low 7 bits for branches) |
| sel_in | input | 3 | Status bit index for codes 1 and 2 |
| sreg_in | input | 8 | Status byte |
| regs_eq_in | input | 1 | The two compared registers are equal |
| bit_val_in | input | 1 | Value of the tested register or I/O bit |
| zptr_in | input | 16 | Indirect jump pointer |
| next_two_word_in | input | 1 | Following instruction is two words long |
| next_pc_o | output | PC_W (22) | Next program counter |
| taken_o | output | 1 | Flow left the sequential path |
| cycles_o | output | 2 | Cycles the instruction occupies (1 to 3) |

## Verification
The assertions assume the inputs are settled before each rising edge and that every value of the operation code, including unused ones, may appear; they judge each output against the inputs of the edge before, and only once one full edge has passed since reset. The stimulus changes inputs only on falling edges, covers every code value with random operands, and adds directed vectors at the wrap points of the counter, at the extremes of both displacement widths and with the ignored displacement bits set.

// File: rtl/brskip_pkg.sv
package brskip_pkg;

    typedef enum logic [3:0] {
        OP_SEQ     = 4'd0,
        OP_BR_SET  = 4'd1,
        OP_BR_CLR  = 4'd2,
        OP_BR_GE   = 4'd3,
        OP_BR_LT   = 4'd4,
        OP_RJMP    = 4'd5,
        OP_IJMP    = 4'd6,
        OP_SK_EQ   = 4'd7,
        OP_SK_BCLR = 4'd8,
        OP_SK_BSET = 4'd9
    } op_e;

    localparam int FLAG_NEG = 2;
    localparam int FLAG_OVF = 3;

    localparam logic [1:0] CYC_ONE   = 2'd1;
    localparam logic [1:0] CYC_TWO   = 2'd2;
    localparam logic [1:0] CYC_THREE = 2'd3;

endpackage

// File: rtl/brskip_cond.sv
module brskip_cond
    import brskip_pkg::*;
#(
    parameter int SREG_W = 8,
    localparam int SEL_W = $clog2(SREG_W)
) (
    input  op_e               op,
    input  logic [SREG_W-1:0] sreg,
    input  logic [SEL_W-1:0]  sel,
    input  logic              regs_eq,
    input  logic              bit_val,
    output logic              is_branch,
    output logic              is_skip,
    output logic              branch_hit,
    output logic              skip_hit
);
    logic sel_bit;
    logic signed_lt;

    assign sel_bit   = sreg[sel];
    assign signed_lt = sreg[FLAG_NEG] ^ sreg[FLAG_OVF];

    always_comb begin
        is_branch  = 1'b0;
        is_skip    = 1'b0;
        branch_hit = 1'b0;
        skip_hit   = 1'b0;
        unique case (op)
            OP_BR_SET: begin
                is_branch  = 1'b1;
                branch_hit = sel_bit;
            end
            OP_BR_CLR: begin
                is_branch  = 1'b1;
                branch_hit = ~sel_bit;
            end
            OP_BR_GE: begin
                is_branch  = 1'b1;
                branch_hit = ~signed_lt;
            end
            OP_BR_LT: begin
                is_branch  = 1'b1;
                branch_hit = signed_lt;
            end
            OP_SK_EQ: begin
                is_skip  = 1'b1;
                skip_hit = regs_eq;
            end
            OP_SK_BCLR: begin
                is_skip  = 1'b1;
                skip_hit = ~bit_val;
            end
            OP_SK_BSET: begin
                is_skip  = 1'b1;
                skip_hit = bit_val;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/brskip_target.sv
module brskip_target #(
    parameter int PC_W      = 22,
    parameter int OFF_W     = 12,
    parameter int BR_OFF_W  = 7,
    parameter int PTR_W     = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [PTR_W-1:0] zptr,
    input  logic             two_word,
    output logic [PC_W-1:0]  pc_seq,
    output logic [PC_W-1:0]  pc_branch,
    output logic [PC_W-1:0]  pc_jump,
    output logic [PC_W-1:0]  pc_indirect,
    output logic [PC_W-1:0]  pc_skip
);
    localparam int BR_EXT  = PC_W - BR_OFF_W;
    localparam int JMP_EXT = PC_W - OFF_W;

    logic [PC_W-1:0] br_disp;
    logic [PC_W-1:0] jmp_disp;
    logic [PC_W-1:0] skip_step;

    assign br_disp  = {{BR_EXT{offset[BR_OFF_W-1]}}, offset[BR_OFF_W-1:0]};
    assign jmp_disp = {{JMP_EXT{offset[OFF_W-1]}}, offset};

    assign pc_seq    = pc + PC_W'(1);
    assign pc_branch = pc_seq + br_disp;
    assign pc_jump   = pc_seq + jmp_disp;

    assign skip_step = two_word ? PC_W'(3) : PC_W'(2);
    assign pc_skip   = pc + skip_step;

    generate
        if (PC_W > PTR_W) begin : g_ptr_zext
            assign pc_indirect = {{(PC_W-PTR_W){1'b0}}, zptr};
        end else begin : g_ptr_trunc
            assign pc_indirect = zptr[PC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/brskip_pc.sv
module brskip_pc
    import brskip_pkg::*;
#(
    parameter int PC_W     = 22,
    parameter int OFF_W    = 12,
    parameter int BR_OFF_W = 7,
    parameter int PTR_W    = 16,
    parameter int SREG_W   = 8,
    localparam int SEL_W   = $clog2(SREG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [3:0]        op_in,
    input  logic [OFF_W-1:0]  offset_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [SREG_W-1:0] sreg_in,
    input  logic              regs_eq_in,
    input  logic              bit_val_in,
    input  logic [PTR_W-1:0]  zptr_in,
    input  logic              next_two_word_in,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic [1:0]        cycles_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
        logic [1:0]      cyc;
    } flow_t;

    op_e             op;
    logic            is_branch, is_skip, branch_hit, skip_hit;
    logic [PC_W-1:0] pc_seq, pc_branch, pc_jump, pc_indirect, pc_skip;
    flow_t           flow_d, flow_q;

    assign op = op_e'(op_in);

    brskip_cond #(.SREG_W(SREG_W)) u_cond (
        .op         (op),
        .sreg       (sreg_in),
        .sel        (sel_in),
        .regs_eq    (regs_eq_in),
        .bit_val    (bit_val_in),
        .is_branch  (is_branch),
        .is_skip    (is_skip),
        .branch_hit (branch_hit),
        .skip_hit   (skip_hit)
    );

    brskip_target #(
        .PC_W     (PC_W),
        .OFF_W    (OFF_W),
        .BR_OFF_W (BR_OFF_W),
        .PTR_W    (PTR_W)
    ) u_target (
        .pc          (pc_in),
        .offset      (offset_in),
        .zptr        (zptr_in),
        .two_word    (next_two_word_in),
        .pc_seq      (pc_seq),
        .pc_branch   (pc_branch),
        .pc_jump     (pc_jump),
        .pc_indirect (pc_indirect),
        .pc_skip     (pc_skip)
    );

    always_comb begin
        flow_d.pc    = pc_seq;
        flow_d.taken = 1'b0;
        flow_d.cyc   = CYC_ONE;
        if (is_branch && branch_hit) begin
            flow_d.pc    = pc_branch;
            flow_d.taken = 1'b1;
            flow_d.cyc   = CYC_TWO;
        end else if (is_skip && skip_hit) begin
            flow_d.pc    = pc_skip;
            flow_d.taken = 1'b1;
            flow_d.cyc   = next_two_word_in ? CYC_THREE : CYC_TWO;
        end else if (op == OP_RJMP) begin
            flow_d.pc    = pc_jump;
            flow_d.taken = 1'b1;
            flow_d.cyc   = CYC_TWO;
        end else if (op == OP_IJMP) begin
            flow_d.pc    = pc_indirect;
            flow_d.taken = 1'b1;
            flow_d.cyc   = CYC_TWO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q <= '0;
        end else begin
            flow_q <= flow_d;
        end
    end

    assign next_pc_o = flow_q.pc;
    assign taken_o   = flow_q.taken;
    assign cycles_o  = flow_q.cyc;
endmodule

// File: rtl/brskip_checker.sv
module brskip_checker
    import brskip_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int PTR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc_in,
    input logic [3:0]      op_in,
    input logic [PTR_W-1:0] zptr_in,
    input logic            next_two_word_in,
    input logic [PC_W-1:0] next_pc_o,
    input logic            taken_o,
    input logic [1:0]      cycles_o
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: outputs cleared while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (next_pc_o == '0 && !taken_o && cycles_o == 2'd0);
        end
    end

    // R1 / R2: once running, every instruction occupies 1 to 3 cycles
    a_r2_cycles_range: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cycles_o != 2'd0));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_in) == 4'd0) |->
        (next_pc_o == $past(pc_in) + PC_W'(1) && !taken_o && cycles_o == 2'd1));

    a_r4_branch_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_in) >= 4'd1 && $past(op_in) <= 4'd4) |->
        (cycles_o == (taken_o ? 2'd2 : 2'd1)));

    a_r6_rjmp_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_in) == 4'd5) |-> (taken_o && cycles_o == 2'd2));

    a_r7_ijmp_target: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_in) == 4'd6) |->
        (next_pc_o == PC_W'($past(zptr_in)) && taken_o && cycles_o == 2'd2));

    a_r8_skip_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_in) >= 4'd7 && $past(op_in) <= 4'd9 && !taken_o) |->
        (next_pc_o == $past(pc_in) + PC_W'(1) && cycles_o == 2'd1));

    a_r9_skip_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_in) >= 4'd7 && $past(op_in) <= 4'd9 && taken_o) |->
        (cycles_o == ($past(next_two_word_in) ? 2'd3 : 2'd2) &&
         next_pc_o == $past(pc_in) + ($past(next_two_word_in) ? PC_W'(3) : PC_W'(2))));
endmodule

bind brskip_pc brskip_checker #(.PC_W(PC_W), .PTR_W(PTR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pc_in            (pc_in),
    .op_in            (op_in),
    .zptr_in          (zptr_in),
    .next_two_word_in (next_two_word_in),
    .next_pc_o        (next_pc_o),
    .taken_o          (taken_o),
    .cycles_o         (cycles_o)
);

// File: tb/brskip_pc_bench.sv
`timescale 1ns/1ps
module brskip_pc_bench;
    localparam int PC_W = 22;
    localparam longint MASK = (64'd1 << PC_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic [3:0]      op_in = '0;
    logic [11:0]     offset_in = '0;
    logic [2:0]      sel_in = '0;
    logic [7:0]      sreg_in = '0;
    logic            regs_eq_in = 1'b0;
    logic            bit_val_in = 1'b0;
    logic [15:0]     zptr_in = '0;
    logic            next_two_word_in = 1'b0;
    logic [PC_W-1:0] next_pc_o;
    logic            taken_o;
    logic [1:0]      cycles_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    brskip_pc u_brskip_pc (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .op_in(op_in),
        .offset_in(offset_in), .sel_in(sel_in), .sreg_in(sreg_in),
        .regs_eq_in(regs_eq_in), .bit_val_in(bit_val_in), .zptr_in(zptr_in),
        .next_two_word_in(next_two_word_in), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .cycles_o(cycles_o)
    );

    function automatic string tag_of(input int op);
        if (op == 1 || op == 2) return "R3";
        if (op == 3 || op == 4) return "R5";
        if (op == 5) return "R6";
        if (op == 6) return "R7";
        if (op >= 7 && op <= 9) return "R8";
        return "R2";
    endfunction

    // behavioural reference: integers, one decision per requirement
    function automatic void model(output longint epc, output bit etk, output int ecy);
        longint pc = longint'(pc_in);
        longint br = longint'($signed(offset_in[6:0]));
        longint jp = longint'($signed(offset_in));
        bit nv = sreg_in[2] ^ sreg_in[3];
        bit hit = 0;
        int op = int'(op_in);
        epc = (pc + 1) & MASK; etk = 0; ecy = 1;
        case (op)
            1: hit = sreg_in[sel_in];
            2: hit = !sreg_in[sel_in];
            3: hit = !nv;
            4: hit = nv;
            default: hit = 0;
        endcase
        if (op >= 1 && op <= 4 && hit) begin
            epc = (pc + br + 1) & MASK; etk = 1; ecy = 2;
        end
        if (op == 5) begin epc = (pc + jp + 1) & MASK; etk = 1; ecy = 2; end
        if (op == 6) begin epc = longint'(zptr_in); etk = 1; ecy = 2; end
        if (op >= 7 && op <= 9) begin
            hit = (op == 7) ? regs_eq_in : (op == 8) ? !bit_val_in : bit_val_in;
            if (hit) begin
                etk = 1;
                ecy = next_two_word_in ? 3 : 2;
                epc = (pc + longint'(ecy)) & MASK;
            end
        end
    endfunction

    task automatic check_now(input string tag, input longint epc, input bit etk, input int ecy);
        checks++;
        if (longint'(next_pc_o) != epc || taken_o != etk || int'(cycles_o) != ecy) begin
            errors++;
            $display("FAIL %s op=%0d: got pc=%h taken=%0d cyc=%0d, expected pc=%h taken=%0d cyc=%0d",
                     tag, op_in, next_pc_o, taken_o, cycles_o, epc, etk, ecy);
        end
    endtask

    // drive at falling edge, compare after the next rising edge
    task automatic apply(input string tag, input logic [3:0] op, input logic [PC_W-1:0] pc,
                         input logic [11:0] off, input logic [2:0] sel, input logic [7:0] sr,
                         input bit eq, input bit bv, input logic [15:0] z, input bit tw);
        longint epc; bit etk; int ecy;
        op_in = op; pc_in = pc; offset_in = off; sel_in = sel; sreg_in = sr;
        regs_eq_in = eq; bit_val_in = bv; zptr_in = z; next_two_word_in = tw;
        model(epc, etk, ecy);
        @(posedge clk);
        @(negedge clk);
        check_now(tag, epc, etk, ecy);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now("R1", 0, 0, 0);
        op_in = 4'd5; pc_in = 22'h1234;
        @(negedge clk);
        check_now("R1", 0, 0, 0);
        rst_n = 1'b1;
        check_now("R1", 0, 0, 0);

        apply("R2", 4'd0, 22'h000100, 12'h7FF, 3'd0, 8'hFF, 1, 1, 16'hBEEF, 1);
        apply("R2", 4'd12, 22'h000200, 12'h001, 3'd1, 8'hFF, 1, 1, 16'h0000, 0);
        apply("R3", 4'd1, 22'h000300, 12'h010, 3'd1, 8'h02, 0, 0, 16'h0, 0);
        apply("R3", 4'd1, 22'h000300, 12'h010, 3'd1, 8'hFD, 0, 0, 16'h0, 0);
        apply("R3", 4'd2, 22'h000400, 12'h07F, 3'd7, 8'h7F, 0, 0, 16'h0, 0);
        apply("R3", 4'd2, 22'h000400, 12'h07F, 3'd7, 8'h80, 0, 0, 16'h0, 0);
        apply("R4", 4'd1, 22'h000500, 12'hF85, 3'd0, 8'h01, 0, 0, 16'h0, 0);
        apply("R4", 4'd1, 22'h000500, 12'h040, 3'd0, 8'h01, 0, 0, 16'h0, 0);
        apply("R5", 4'd3, 22'h000600, 12'h008, 3'd2, 8'h0C, 0, 0, 16'h0, 0);
        apply("R5", 4'd3, 22'h000600, 12'h008, 3'd2, 8'h14, 0, 0, 16'h0, 0);
        apply("R5", 4'd4, 22'h000600, 12'h008, 3'd4, 8'h04, 0, 0, 16'h0, 0);
        apply("R5", 4'd4, 22'h000600, 12'h008, 3'd4, 8'h10, 0, 0, 16'h0, 0);
        apply("R6", 4'd5, 22'h000800, 12'h800, 3'd0, 8'h00, 0, 0, 16'h0, 0);
        apply("R6", 4'd5, 22'h000800, 12'h7FF, 3'd0, 8'h00, 0, 0, 16'h0, 0);
        apply("R7", 4'd6, 22'h3FFFFF, 12'h123, 3'd0, 8'h00, 0, 0, 16'hFFFF, 0);
        apply("R8", 4'd7, 22'h000900, 12'h0, 3'd0, 8'h00, 0, 1, 16'h0, 1);
        apply("R8", 4'd8, 22'h000900, 12'h0, 3'd0, 8'h00, 1, 1, 16'h0, 1);
        apply("R8", 4'd9, 22'h000900, 12'h0, 3'd0, 8'h00, 1, 0, 16'h0, 1);
        apply("R9", 4'd7, 22'h000A00, 12'h0, 3'd0, 8'h00, 1, 0, 16'h0, 0);
        apply("R9", 4'd8, 22'h000A00, 12'h0, 3'd0, 8'h00, 0, 0, 16'h0, 1);
        apply("R9", 4'd9, 22'h000A00, 12'h0, 3'd0, 8'h00, 0, 1, 16'h0, 1);
        apply("R10", 4'd0, 22'h3FFFFF, 12'h0, 3'd0, 8'h00, 0, 0, 16'h0, 0);
        apply("R10", 4'd9, 22'h3FFFFE, 12'h0, 3'd0, 8'h00, 0, 1, 16'h0, 1);
        apply("R10", 4'd5, 22'h000002, 12'hFF0, 3'd0, 8'h00, 0, 0, 16'h0, 0);
        apply("R10", 4'd2, 22'h3FFFF0, 12'h03F, 3'd3, 8'h00, 0, 0, 16'h0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            logic [PC_W-1:0] pc = PC_W'($urandom);
            if (i % 7 == 0) pc = PC_W'(MASK - longint'($urandom_range(0, 3)));
            apply(tag_of(int'(op)), op, pc, 12'($urandom), 3'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule